// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose Port

This block is an eight-pin general-purpose port of the kind found on small 8-bit controllers. Each pin has a storage latch. A latch holding 0 turns on a pull-down that forces the pin low. A latch holding 1 releases the pin to a weak pull-up, and an outside source can still drag the pin low. Software therefore makes a pin an input by writing 1 to its latch and then sampling the pin.

The processor side has four operations. A whole-byte write loads all latches. A single-bit operation sets, clears or inverts one latch, starting from the latch contents and never from the pins. A pin-read strobe captures the resolved pin levels. A latch-read strobe captures the stored latch values. The outside side receives one pull-down enable per pin and returns the level seen on each pin. The resolved pin level is the AND of the latch and that external level.

Top module: `qb_port`

## Requirements
- R1: While reset is active and after its release, every latch holds 1, every pull-down enable is 0 and the read data register is 0.
- R2: A byte write loads all latches from the write data on the next clock edge. Latches keep their value in any cycle with no write and no bit operation.
- R3: The pull-down enable of a pin is 1 exactly when its latch holds 0, and a pin whose pull-down is on always resolves low.
- R4: A pin-read strobe loads the read data register on the next edge with the AND of each latch and its external level.
- R5: A latch-read strobe with no pin-read strobe loads the read data register with the latch values, whatever the external levels are.
- R6: A bit operation acts only on the latch picked by the bit index. Op code 0 clears it, 1 sets it, 2 inverts it and 3 leaves it unchanged. All other latches keep their values.
- R7: A bit operation takes its starting value from the latch, so a pin held low from outside while its latch holds 1 is not written back as 0.
- R8: When a byte write and a bit operation fall in the same cycle, the bit operation is applied to the newly written byte.
- R9: With no read strobe the read data register holds its value. With both strobes in one cycle the pin read wins.
- R10: A latch read in the same cycle as a write returns the latch contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_byte_en | input | 1 | Whole-byte latch write strobe |
| wr_byte_data | input | 8 | Data for a byte write |
| bit_op_en | input | 1 | Single-bit operation strobe |
| bit_sel | input | 3 | Index of the latch a bit operation acts on |
| bit_op | input | 2 | 0 clear, 1 set, 2 invert, 3 no change |
| rd_pin_en | input | 1 | Capture resolved pin levels |
| rd_latch_en | input | 1 | Capture latch values |
| rd_data | output | 8 | Read data register |
| ext_level | input | 8 | Level driven onto each pin from outside (0 pulls low) |
| pull_dn | output | 8 | Per-pin pull-down enable |

## Verification
Three kinds of coincidence are the main risks: a byte write and a bit operation in one cycle, a read in the same cycle as a write, and both read strobes together. Random stimulus turns every strobe on and off on its own, so all of these coincidences occur many times. Directed cases also force each of them once with known values. The bench keeps a model of the latches and of the read register, built from the stated ordering. That ordering is: the byte write first, then the bit operation, then the read of the pre-edge values with the pin read taking priority. Both outputs are compared with the model after every clock edge.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
   typedef enum logic [1:0] {
      BOP_CLR  = 2'd0,
      BOP_SET  = 2'd1,
      BOP_INV  = 2'd2,
      BOP_KEEP = 2'd3
   } bit_op_e;

   function automatic logic apply_bit_op(input logic base, input bit_op_e op);
      case (op)
         BOP_CLR: return 1'b0;
         BOP_SET: return 1'b1;
         BOP_INV: return ~base;
         default: return base;
      endcase
   endfunction
endpackage

// File: rtl/qbp_latch_bank.sv
module qbp_latch_bank
   import qb_port_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             bop_en,
   input  logic [SEL_W-1:0] bop_sel,
   input  bit_op_e          bop,
   output logic [WIDTH-1:0] latch_q
);
   logic [WIDTH-1:0] base_v;
   logic [WIDTH-1:0] next_v;
   logic [WIDTH-1:0] sel_mask;

   always_comb begin
      sel_mask = '0;
      for (int i = 0; i < WIDTH; i++)
         if (bop_sel == SEL_W'(i)) sel_mask[i] = 1'b1;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign base_v[g] = wr_en ? wr_data[g] : latch_q[g];
      assign next_v[g] = (bop_en && sel_mask[g]) ? apply_bit_op(base_v[g], bop) : base_v[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) latch_q[g] <= 1'b1;
         else        latch_q[g] <= next_v[g];
      end
   end

   p_byte_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bop_en) |=> (latch_q == $past(wr_data)));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !bop_en) |=> $stable(latch_q));
   p_others_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bop_en && !wr_en) |=> (((latch_q ^ $past(latch_q)) & ~$past(sel_mask)) == '0));
   p_keep_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bop_en && !wr_en && bop == BOP_KEEP) |=> $stable(latch_q));
endmodule

// File: rtl/qbp_pin_resolve.sv
module qbp_pin_resolve #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] ext_level,
   output logic [WIDTH-1:0] pin_level,
   output logic [WIDTH-1:0] pull_dn
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_pin
      assign pull_dn[g]   = ~latch_q[g];
      assign pin_level[g] = latch_q[g] & ext_level[g];
   end

   p_pulled_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pull_dn & pin_level) == '0));
endmodule

// File: rtl/qbp_read_path.sv
module qbp_read_path #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_pin_en,
   input  logic             rd_latch_en,
   input  logic [WIDTH-1:0] pin_level,
   input  logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rd_data <= '0;
      else if (rd_pin_en)   rd_data <= pin_level;
      else if (rd_latch_en) rd_data <= latch_q;
   end

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));
   p_rd_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_latch_en && !rd_pin_en) |=> (rd_data == $past(latch_q)));
   p_rd_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pin_en |=> (rd_data == $past(pin_level)));
endmodule

// File: rtl/qb_port.sv
module qb_port
   import qb_port_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic [WIDTH-1:0] wr_byte_data,
   input  logic             bit_op_en,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic [1:0]       bit_op,
   input  logic             rd_pin_en,
   input  logic             rd_latch_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] ext_level,
   output logic [WIDTH-1:0] pull_dn
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("qb_port: WIDTH must lie in 1..64");
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_level;
   bit_op_e          op_e;

   assign op_e = bit_op_e'(bit_op);

   qbp_latch_bank #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_latch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_byte_en), .wr_data(wr_byte_data),
      .bop_en(bit_op_en), .bop_sel(bit_sel), .bop(op_e),
      .latch_q(latch_q)
   );

   qbp_pin_resolve #(.WIDTH(WIDTH)) i_pins (
      .clk(clk), .rst_n(rst_n),
      .latch_q(latch_q), .ext_level(ext_level),
      .pin_level(pin_level), .pull_dn(pull_dn)
   );

   qbp_read_path #(.WIDTH(WIDTH)) i_read (
      .clk(clk), .rst_n(rst_n),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
      .pin_level(pin_level), .latch_q(latch_q),
      .rd_data(rd_data)
   );

   p_pin_read_never_above_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pin_en |=> ((rd_data & ~$past(latch_q)) == '0));
endmodule

// File: tb/test_qb_port.sv
module test_qb_port;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_byte_en = 1'b0;
   logic [W-1:0] wr_byte_data = '0;
   logic         bit_op_en = 1'b0;
   logic [2:0]   bit_sel = '0;
   logic [1:0]   bit_op = '0;
   logic         rd_pin_en = 1'b0;
   logic         rd_latch_en = 1'b0;
   logic [W-1:0] rd_data;
   logic [W-1:0] ext_level = '1;
   logic [W-1:0] pull_dn;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_latch;
   logic [W-1:0] m_rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   qb_port i_qb_port (
      .clk(clk), .rst_n(rst_n),
      .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .bit_op_en(bit_op_en), .bit_sel(bit_sel), .bit_op(bit_op),
      .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
      .rd_data(rd_data), .ext_level(ext_level), .pull_dn(pull_dn)
   );

   function automatic logic [W-1:0] next_latch(input logic [W-1:0] cur,
      input logic we, input logic [W-1:0] wd, input logic be,
      input logic [2:0] sel, input logic [1:0] op);
      logic [W-1:0] v;
      v = we ? wd : cur;
      if (be) begin
         case (op)
            2'd0: v[sel] = 1'b0;
            2'd1: v[sel] = 1'b1;
            2'd2: v[sel] = ~v[sel];
            default: ;
         endcase
      end
      return v;
   endfunction

   function automatic logic [W-1:0] next_rd(input logic [W-1:0] cur,
      input logic [W-1:0] lat, input logic [W-1:0] ext, input logic rp, input logic rl);
      if (rp) return lat & ext;
      if (rl) return lat;
      return cur;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one cycle at the falling edge, update the model, check after the rising edge
   task automatic step(input string tag, input logic we, input logic [W-1:0] wd,
      input logic be, input logic [2:0] sel, input logic [1:0] op,
      input logic rp, input logic rl, input logic [W-1:0] ext);
      wr_byte_en = we; wr_byte_data = wd; bit_op_en = be; bit_sel = sel; bit_op = op;
      rd_pin_en = rp; rd_latch_en = rl; ext_level = ext;
      m_rd    = next_rd(m_rd, m_latch, ext, rp, rl);
      m_latch = next_latch(m_latch, we, wd, be, sel, op);
      @(posedge clk);
      @(negedge clk);
      check({tag, " rd_data"}, rd_data, m_rd);
      check({tag, " pull_dn"}, pull_dn, ~m_latch);
   endtask

   task automatic idle();
      step("R2 idle", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, ext_level);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      m_latch = '1;
      m_rd = '0;
      repeat (3) @(negedge clk);
      check("R1 reset pull_dn", pull_dn, '0);
      check("R1 reset rd_data", rd_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: latches read back as all ones after reset
      step("R1 latch after reset", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'h00);
      // R2: byte write, then read latch
      step("R2 write", 1'b1, 8'hA5, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'hFF);
      step("R2 read back", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'hFF);
      // R3/R4: pin read combines latch with external level
      step("R4 pin read", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b1, 1'b0, 8'h0F);
      // R5: latch read ignores external level
      step("R5 latch read", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'h00);
      // R9: both strobes -> pin read wins; then hold
      step("R9 both strobes", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b1, 1'b1, 8'h3C);
      step("R9 hold", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'hFF);
      // R6: set, clear, invert, keep on single bits
      step("R6 set bit1", 1'b0, '0, 1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 8'hFF);
      step("R6 clear bit7", 1'b0, '0, 1'b1, 3'd7, 2'd0, 1'b0, 1'b0, 8'hFF);
      step("R6 invert bit0", 1'b0, '0, 1'b1, 3'd0, 2'd2, 1'b0, 1'b0, 8'hFF);
      step("R6 keep bit3", 1'b0, '0, 1'b1, 3'd3, 2'd3, 1'b0, 1'b1, 8'hFF);
      // R7: pins held low externally, latch all ones, invert bit 4 -> only bit 4 drops
      step("R7 setup", 1'b1, 8'hFF, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00);
      step("R7 invert with pins low", 1'b0, '0, 1'b1, 3'd4, 2'd2, 1'b1, 1'b0, 8'h00);
      step("R7 read latch", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'h00);
      // R8: byte write plus bit op in one cycle
      step("R8 write plus invert", 1'b1, 8'h0F, 1'b1, 3'd2, 2'd2, 1'b0, 1'b0, 8'hFF);
      step("R8 write plus set", 1'b1, 8'h00, 1'b1, 3'd6, 2'd1, 1'b0, 1'b1, 8'hFF);
      // R10: read in same cycle as write returns previous latch
      step("R10 read during write", 1'b1, 8'h5A, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'hFF);
      step("R10 read after write", 1'b0, '0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 8'hFF);
      idle();
      // random mix: R2 R4 R5 R6 R8 R9 R10 against the model
      for (int i = 0; i < 2000; i++) begin
         step("R8 random", ($urandom % 4) == 0, W'($urandom), ($urandom % 3) == 0,
              3'($urandom), 2'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
              W'($urandom));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule